// File: doc/BRIEF.md
# Command Thread Control Register File

This block is the per-thread control and status register file of a register-writing command engine. Software reaches it over a plain 32-bit register bus. For each hardware thread it holds an enable bit, a pause request, a self-clearing warm reset, a priority field, the program counter and the end address, and a small interrupt status and mask pair. The register contents drive run, flush and reset strobes toward the execution core. The core in turn reports its halted state, program-counter updates and completion or error pulses.

Each thread has its own 0x80-byte register window, and the first window sits at byte 0x100. The low window carries three engine-wide registers: an active-low interrupt summary with one bit per thread, an "any thread executing" flag, and the arbitration time-slice register. A pause request only counts as finished once the core confirms that it has stopped. Any write to the program counter, even of the value already held, tells the core to drop its prefetched instructions.

Top module: `cmd_thread_regs`

## Requirements
- R1: After reset every thread is disabled with PC 0, the pause status bit reads 1, the slot register reads 0x3200 and the global summary at 0x010 reads 0x0000FFFF.
- R2: Thread t decodes at base 0x100 + 0x80*t. The offsets inside a window are: 0x00 warm reset, 0x04 enable, 0x08 pause request, 0x0C status, 0x10 irq status, 0x14 irq mask, 0x20 PC, 0x24 end address, 0x40 priority. An address in a window past the last thread reads 0, and writes to it change nothing.
- R3: Writing 1 to bit 0 of warm reset makes that bit read 1 for RESET_CYCLES cycles, after which it clears by itself. While it reads 1, coreReset is high and coreRun is low. The reset leaves enable, the pause request and irq status at 0.
- R4: coreRun of a thread is high only when the thread is enabled, not paused, not in warm reset, and its PC differs from its end address.
- R5: Status bit 1 (suspended) reads 1 when the thread is disabled, or when a pause is requested and coreHalted is high. With a pause requested and coreHalted low it reads 0. Writing 0 to the pause register resumes the thread. Status bit 0 mirrors coreRun.
- R6: Irq status bit 0 is set by evtDone, bit 1 by evtInstrErr and bit 4 by evtBusErr. A write to irq status keeps exactly the bits written as 1 and clears the rest, so writing the inverse of a read value clears the bits that were read. An event that arrives in the same cycle as a clearing write still sets its bit.
- R7: A bus write to PC stores the value and pulses coreFlush for exactly one cycle, in the cycle after the write. This happens even when the value is unchanged. corePcWe loads corePcNext into PC.
- R8: Bit t of the global summary (0x010) is 0 exactly when thread t has an irq status bit whose mask bit is also set. Bits of threads that do not exist read 1. irqAny is high when any summary bit is 0.
- R9: Bit 31 of 0x018 reads 1 exactly when some thread has coreRun high.
- R10: The slot register (0x030) and the 3-bit priority field are read/write, and they drive slotCycles and threadPrio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe |
| busAddr | input | ADDR_W | Byte address |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, valid the cycle after busRdEn |
| coreRun | output | NUM_THREADS | Per-thread permission to execute |
| coreFlush | output | NUM_THREADS | One-cycle pulse: drop prefetched instructions |
| coreReset | output | NUM_THREADS | Thread warm reset in progress |
| threadPc | output | NUM_THREADS*PC_W | Program counter of each thread |
| threadEnd | output | NUM_THREADS*PC_W | End address of each thread |
| threadPrio | output | NUM_THREADS*3 | Priority of each thread |
| slotCycles | output | 32 | Arbitration time slice |
| coreHalted | input | NUM_THREADS | Core confirms the thread is stopped |
| corePcWe | input | NUM_THREADS | Core PC update strobe |
| corePcNext | input | NUM_THREADS*PC_W | Core PC update value |
| evtDone | input | NUM_THREADS | Completion pulse |
| evtInstrErr | input | NUM_THREADS | Instruction error pulse |
| evtBusErr | input | NUM_THREADS | Bus error pulse |
| irqAny | output | 1 | Some thread has an unmasked interrupt |

## Verification
The hardest case to reach from the ports is an irq event that lands in the same cycle as a software write clearing the same register. The bench gets there by driving the bus write strobe and the event pulse on the same falling edge, outside the write task, and then reading back the one surviving bit. The gap between a requested pause and a confirmed pause is also only visible while coreHalted is held low. The stimulus therefore reads status once before raising coreHalted and once after.

// File: rtl/cte_pkg.sv
package cte_pkg;
  localparam int THR_SEL_W = 8;
  localparam int IRQ_W = 5;
  localparam logic [IRQ_W-1:0] IRQ_LIVE_MASK = 5'h13;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_WARM, SEL_EN, SEL_SUSP, SEL_STAT, SEL_IRQ, SEL_IRQEN,
    SEL_PC, SEL_END, SEL_CFG, SEL_GIRQ, SEL_GEXEC, SEL_SLOT
  } regSel_e;

  typedef struct packed {
    logic wr;
    logic rd;
    regSel_e sel;
    logic [THR_SEL_W-1:0] thr;
  } strobe_t;
endpackage

// File: rtl/cte_ctrl.sv
module cte_ctrl
  import cte_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NUM_THREADS = 3
) (
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           stb
);
  localparam int WIN_W = ADDR_W - 7;
  localparam logic [WIN_W-1:0] FIRST_WIN = WIN_W'(2);

  logic [WIN_W-1:0] winNum;
  logic [6:0] winOff;
  logic [WIN_W-1:0] thrNum;

  assign winNum = busAddr[ADDR_W-1:7];
  assign winOff = busAddr[6:0];
  assign thrNum = winNum - FIRST_WIN;

  always_comb begin
    stb.wr = busWrEn;
    stb.rd = busRdEn;
    stb.sel = SEL_NONE;
    stb.thr = '0;
    if (winNum == '0) begin
      unique case (winOff)
        7'h10: stb.sel = SEL_GIRQ;
        7'h18: stb.sel = SEL_GEXEC;
        7'h30: stb.sel = SEL_SLOT;
        default: stb.sel = SEL_NONE;
      endcase
    end else if (winNum >= FIRST_WIN && 32'(thrNum) < NUM_THREADS) begin
      stb.thr = THR_SEL_W'(thrNum);
      unique case (winOff)
        7'h00: stb.sel = SEL_WARM;
        7'h04: stb.sel = SEL_EN;
        7'h08: stb.sel = SEL_SUSP;
        7'h0C: stb.sel = SEL_STAT;
        7'h10: stb.sel = SEL_IRQ;
        7'h14: stb.sel = SEL_IRQEN;
        7'h20: stb.sel = SEL_PC;
        7'h24: stb.sel = SEL_END;
        7'h40: stb.sel = SEL_CFG;
        default: stb.sel = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/cte_thread.sv
module cte_thread
  import cte_pkg::*;
#(
  parameter int PC_W = 32,
  parameter int RESET_CYCLES = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  regSel_e         wrSel,
  input  regSel_e         rdSel,
  input  logic [31:0]     wrData,
  input  logic            coreHalted,
  input  logic            corePcWe,
  input  logic [PC_W-1:0] corePcNext,
  input  logic            evtDone,
  input  logic            evtInstrErr,
  input  logic            evtBusErr,
  output logic            run,
  output logic            flush,
  output logic            resetBusy,
  output logic [PC_W-1:0] pcOut,
  output logic [PC_W-1:0] endOut,
  output logic [2:0]      prioOut,
  output logic            irqPending,
  output logic [31:0]     rdData
);
  localparam int CNT_W = $clog2(RESET_CYCLES + 1);

  logic enableReg, suspReq, suspended;
  logic [CNT_W-1:0] rstCnt;
  logic [PC_W-1:0] pcReg, endReg;
  logic [2:0] prioReg;
  logic [IRQ_W-1:0] irqStat, irqEn, evtVec;

  assign evtVec = {evtBusErr, 2'b00, evtInstrErr, evtDone};
  assign resetBusy = (rstCnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableReg <= 1'b0;
      suspReq <= 1'b0;
      rstCnt <= '0;
      pcReg <= '0;
      endReg <= '0;
      prioReg <= '0;
      irqStat <= '0;
      irqEn <= '0;
      flush <= 1'b0;
    end else begin
      flush <= (wrSel == SEL_PC);
      if (resetBusy) rstCnt <= rstCnt - CNT_W'(1);
      else if (wrSel == SEL_WARM && wrData[0]) rstCnt <= CNT_W'(RESET_CYCLES);
      if (resetBusy) begin
        enableReg <= 1'b0;
        suspReq <= 1'b0;
        irqStat <= '0;
      end else begin
        if (wrSel == SEL_EN) enableReg <= wrData[0];
        if (wrSel == SEL_SUSP) suspReq <= wrData[0];
        irqStat <= ((wrSel == SEL_IRQ) ? (irqStat & wrData[IRQ_W-1:0]) : irqStat) | evtVec;
      end
      if (wrSel == SEL_PC) pcReg <= wrData[PC_W-1:0];
      else if (corePcWe) pcReg <= corePcNext;
      if (wrSel == SEL_END) endReg <= wrData[PC_W-1:0];
      if (wrSel == SEL_CFG) prioReg <= wrData[2:0];
      if (wrSel == SEL_IRQEN) irqEn <= wrData[IRQ_W-1:0] & IRQ_LIVE_MASK;
    end
  end

  assign run = enableReg & ~suspReq & ~resetBusy & (pcReg != endReg);
  assign suspended = ~enableReg | (suspReq & coreHalted);
  assign irqPending = |(irqStat & irqEn);
  assign pcOut = pcReg;
  assign endOut = endReg;
  assign prioOut = prioReg;

  always_comb begin
    rdData = '0;
    unique case (rdSel)
      SEL_WARM:  rdData = {31'b0, resetBusy};
      SEL_EN:    rdData = {31'b0, enableReg};
      SEL_SUSP:  rdData = {31'b0, suspReq};
      SEL_STAT:  rdData = {30'b0, suspended, run};
      SEL_IRQ:   rdData = {27'b0, irqStat};
      SEL_IRQEN: rdData = {27'b0, irqEn};
      SEL_PC:    rdData = 32'(pcReg);
      SEL_END:   rdData = 32'(endReg);
      SEL_CFG:   rdData = {29'b0, prioReg};
      default:   rdData = '0;
    endcase
  end

  assert_flush_after_pc_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrSel == SEL_PC) |=> (flush && pcReg == $past(wrData[PC_W-1:0])));
  assert_reset_drops_enable_R3: assert property (@(posedge clk) disable iff (!rstN)
    resetBusy |=> !enableReg);
  assert_no_run_at_end_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pcReg == endReg) |-> !run);
  assert_pause_confirmed_R5: assert property (@(posedge clk) disable iff (!rstN)
    (enableReg && suspended) |-> (suspReq && coreHalted));
  assert_done_bit_needs_event_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqStat[0]) |-> $past(evtDone));
endmodule

// File: rtl/cte_datapath.sv
module cte_datapath
  import cte_pkg::*;
#(
  parameter int NUM_THREADS = 3,
  parameter int PC_W = 32,
  parameter int RESET_CYCLES = 4,
  parameter logic [31:0] SLOT_RESET = 32'h3200
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  strobe_t                     stb,
  input  logic [31:0]                 wrData,
  output logic [31:0]                 rdData,
  output logic [NUM_THREADS-1:0]      runVec,
  output logic [NUM_THREADS-1:0]      flushVec,
  output logic [NUM_THREADS-1:0]      resetVec,
  output logic [NUM_THREADS*PC_W-1:0] pcVec,
  output logic [NUM_THREADS*PC_W-1:0] endVec,
  output logic [NUM_THREADS*3-1:0]    prioVec,
  output logic [31:0]                 slotOut,
  input  logic [NUM_THREADS-1:0]      coreHalted,
  input  logic [NUM_THREADS-1:0]      corePcWe,
  input  logic [NUM_THREADS*PC_W-1:0] corePcNext,
  input  logic [NUM_THREADS-1:0]      evtDone,
  input  logic [NUM_THREADS-1:0]      evtInstrErr,
  input  logic [NUM_THREADS-1:0]      evtBusErr,
  output logic                        irqAny
);
  localparam int SUM_W = 16;

  logic [NUM_THREADS-1:0] pendVec;
  logic [31:0] thrRd [NUM_THREADS];
  logic [31:0] slotReg, rdNext, rdThread;
  logic [SUM_W-1:0] summary;
  logic isGlobal;

  assign isGlobal = (stb.sel == SEL_GIRQ) || (stb.sel == SEL_GEXEC) || (stb.sel == SEL_SLOT);

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    regSel_e wrSelT;
    assign wrSelT = (stb.wr && !isGlobal && stb.thr == THR_SEL_W'(t)) ? stb.sel : SEL_NONE;
    cte_thread #(.PC_W(PC_W), .RESET_CYCLES(RESET_CYCLES)) u_thr (
      .clk(clk), .rstN(rstN), .wrSel(wrSelT), .rdSel(stb.sel), .wrData(wrData),
      .coreHalted(coreHalted[t]), .corePcWe(corePcWe[t]),
      .corePcNext(corePcNext[t*PC_W +: PC_W]),
      .evtDone(evtDone[t]), .evtInstrErr(evtInstrErr[t]), .evtBusErr(evtBusErr[t]),
      .run(runVec[t]), .flush(flushVec[t]), .resetBusy(resetVec[t]),
      .pcOut(pcVec[t*PC_W +: PC_W]), .endOut(endVec[t*PC_W +: PC_W]),
      .prioOut(prioVec[t*3 +: 3]), .irqPending(pendVec[t]), .rdData(thrRd[t])
    );
  end

  always_comb begin
    summary = '1;
    for (int t = 0; t < NUM_THREADS; t++) summary[t] = ~pendVec[t];
  end
  assign irqAny = |pendVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) slotReg <= SLOT_RESET;
    else if (stb.wr && stb.sel == SEL_SLOT) slotReg <= wrData;
  end
  assign slotOut = slotReg;

  always_comb begin
    rdThread = '0;
    for (int t = 0; t < NUM_THREADS; t++)
      if (stb.thr == THR_SEL_W'(t)) rdThread = thrRd[t];
  end

  always_comb begin
    unique case (stb.sel)
      SEL_NONE:  rdNext = '0;
      SEL_GIRQ:  rdNext = {16'b0, summary};
      SEL_GEXEC: rdNext = {|runVec, 31'b0};
      SEL_SLOT:  rdNext = slotReg;
      default:   rdNext = rdThread;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else if (stb.rd) rdData <= rdNext;
  end

  assert_idle_summary_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (summary == '1) |-> !irqAny);
  assert_reset_blocks_run_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((resetVec & runVec) == '0));
endmodule

// File: rtl/cmd_thread_regs.sv
module cmd_thread_regs
  import cte_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NUM_THREADS = 3,
  parameter int PC_W = 32,
  parameter int RESET_CYCLES = 4,
  parameter logic [31:0] SLOT_RESET = 32'h3200
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        busWrEn,
  input  logic                        busRdEn,
  input  logic [ADDR_W-1:0]           busAddr,
  input  logic [31:0]                 busWrData,
  output logic [31:0]                 busRdData,
  output logic [NUM_THREADS-1:0]      coreRun,
  output logic [NUM_THREADS-1:0]      coreFlush,
  output logic [NUM_THREADS-1:0]      coreReset,
  output logic [NUM_THREADS*PC_W-1:0] threadPc,
  output logic [NUM_THREADS*PC_W-1:0] threadEnd,
  output logic [NUM_THREADS*3-1:0]    threadPrio,
  output logic [31:0]                 slotCycles,
  input  logic [NUM_THREADS-1:0]      coreHalted,
  input  logic [NUM_THREADS-1:0]      corePcWe,
  input  logic [NUM_THREADS*PC_W-1:0] corePcNext,
  input  logic [NUM_THREADS-1:0]      evtDone,
  input  logic [NUM_THREADS-1:0]      evtInstrErr,
  input  logic [NUM_THREADS-1:0]      evtBusErr,
  output logic                        irqAny
);
  strobe_t stb;

  cte_ctrl #(.ADDR_W(ADDR_W), .NUM_THREADS(NUM_THREADS)) u_ctrl (
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr), .stb(stb)
  );

  cte_datapath #(.NUM_THREADS(NUM_THREADS), .PC_W(PC_W), .RESET_CYCLES(RESET_CYCLES),
                 .SLOT_RESET(SLOT_RESET)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(busWrData), .rdData(busRdData),
    .runVec(coreRun), .flushVec(coreFlush), .resetVec(coreReset),
    .pcVec(threadPc), .endVec(threadEnd), .prioVec(threadPrio), .slotOut(slotCycles),
    .coreHalted(coreHalted), .corePcWe(corePcWe), .corePcNext(corePcNext),
    .evtDone(evtDone), .evtInstrErr(evtInstrErr), .evtBusErr(evtBusErr), .irqAny(irqAny)
  );
endmodule

// File: tb/sim_cmd_thread_regs.sv
module sim_cmd_thread_regs;
  localparam int NT = 3;
  localparam int PW = 32;

  logic clk = 0, rstN = 0;
  logic busWrEn = 0, busRdEn = 0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWrData = '0, busRdData;
  logic [NT-1:0] coreRun, coreFlush, coreReset;
  logic [NT*PW-1:0] threadPc, threadEnd;
  logic [NT*3-1:0] threadPrio;
  logic [31:0] slotCycles;
  logic [NT-1:0] coreHalted = '0, corePcWe = '0;
  logic [NT*PW-1:0] corePcNext = '0;
  logic [NT-1:0] evtDone = '0, evtInstrErr = '0, evtBusErr = '0;
  logic irqAny;

  int checks = 0, failures = 0;
  logic [31:0] expQ[$], maskQ[$];
  string tagQ[$];
  logic rdIssued = 0;

  always #5 clk = ~clk;

  cmd_thread_regs u0 (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .coreRun(coreRun), .coreFlush(coreFlush),
    .coreReset(coreReset), .threadPc(threadPc), .threadEnd(threadEnd), .threadPrio(threadPrio),
    .slotCycles(slotCycles), .coreHalted(coreHalted), .corePcWe(corePcWe),
    .corePcNext(corePcNext), .evtDone(evtDone), .evtInstrErr(evtInstrErr),
    .evtBusErr(evtBusErr), .irqAny(irqAny)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input logic [31:0] mask,
                    input string tag);
    @(negedge clk);
    busRdEn = 1; busAddr = a;
    expQ.push_back(exp); maskQ.push_back(mask); tagQ.push_back(tag);
    @(negedge clk);
    busRdEn = 0;
  endtask

  always @(posedge clk) rdIssued <= busRdEn;

  initial begin
    forever begin
      @(negedge clk);
      if (rdIssued && expQ.size() > 0) begin
        logic [31:0] e, m;
        string tg;
        e = expQ.pop_front(); m = maskQ.pop_front(); tg = tagQ.pop_front();
        chk(busRdData & m, e & m, tg);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    rd(12'h104, 0, 32'hFFFFFFFF, "R1 enable after reset");
    rd(12'h030, 32'h3200, 32'hFFFFFFFF, "R1 slot default");
    rd(12'h010, 32'h0000FFFF, 32'hFFFFFFFF, "R1 summary idle");
    rd(12'h10C, 32'h2, 32'hFFFFFFFF, "R1 disabled reads suspended");
    rd(12'h120, 0, 32'hFFFFFFFF, "R1 pc after reset");
    chk(32'(coreRun), 0, "R1 no thread runs");

    // R7 PC write and flush on thread1
    wr(12'h1A4, 32'h40);
    wr(12'h1A0, 32'h10);
    chk(32'(coreFlush), 32'b010, "R7 flush pulse");
    chk(threadPc[PW +: PW], 32'h10, "R7 pc output");
    @(negedge clk);
    chk(32'(coreFlush), 0, "R7 flush one cycle");

    // R4 enable
    wr(12'h184, 1);
    chk(32'(coreRun[1]), 1, "R4 run when enabled");
    rd(12'h18C, 32'h1, 32'hFFFFFFFF, "R5 status running");
    rd(12'h018, 32'h80000000, 32'h80000000, "R9 exec flag set");

    // R5 pause
    wr(12'h188, 1);
    chk(32'(coreRun[1]), 0, "R5 pause stops run");
    rd(12'h18C, 32'h0, 32'hFFFFFFFF, "R5 not yet confirmed");
    coreHalted[1] = 1;
    rd(12'h18C, 32'h2, 32'hFFFFFFFF, "R5 confirmed pause");
    wr(12'h188, 0);
    coreHalted[1] = 0;
    chk(32'(coreRun[1]), 1, "R5 resume");

    // R4 halt at end via core PC update
    @(negedge clk);
    corePcWe[1] = 1; corePcNext[PW +: PW] = 32'h40;
    @(negedge clk);
    corePcWe[1] = 0;
    chk(32'(coreRun[1]), 0, "R4 halt at end");
    rd(12'h1A0, 32'h40, 32'hFFFFFFFF, "R7 core pc update");
    rd(12'h018, 32'h0, 32'h80000000, "R9 exec flag clear");
    wr(12'h1A0, 32'h40);
    chk(32'(coreFlush), 32'b010, "R7 flush on same value");
    wr(12'h1A0, 32'h20);
    chk(32'(coreRun[1]), 1, "R4 run after pc moved");

    // R2 thread2 window and separation
    wr(12'h220, 32'hABC);
    rd(12'h220, 32'hABC, 32'hFFFFFFFF, "R2 thread2 pc");
    chk(threadPc[2*PW +: PW], 32'hABC, "R2 thread2 pc output");
    rd(12'h1A0, 32'h20, 32'hFFFFFFFF, "R2 thread1 pc untouched");
    wr(12'h284, 1);
    rd(12'h284, 32'h0, 32'hFFFFFFFF, "R2 missing thread reads 0");
    chk(32'(coreRun), 32'b010, "R2 missing thread write ignored");
    rd(12'h000, 32'h0, 32'hFFFFFFFF, "R2 unmapped reads 0");

    // R6/R8 irq
    wr(12'h194, 32'h13);
    @(negedge clk);
    evtDone[1] = 1; evtBusErr[1] = 1;
    @(negedge clk);
    evtDone[1] = 0; evtBusErr[1] = 0;
    rd(12'h190, 32'h11, 32'hFFFFFFFF, "R6 done and bus error set");
    rd(12'h010, 32'hFFFD, 32'hFFFFFFFF, "R8 summary thread1 low");
    chk(32'(irqAny), 1, "R8 irqAny high");
    wr(12'h190, ~32'h01);
    rd(12'h190, 32'h10, 32'hFFFFFFFF, "R6 inverse write clears done only");
    wr(12'h190, ~32'h10);
    rd(12'h010, 32'hFFFF, 32'hFFFFFFFF, "R8 summary idle again");
    chk(32'(irqAny), 0, "R8 irqAny low");
    @(negedge clk);
    evtInstrErr[0] = 1;
    @(negedge clk);
    evtInstrErr[0] = 0;
    rd(12'h110, 32'h02, 32'hFFFFFFFF, "R6 instr error bit1");
    rd(12'h010, 32'hFFFF, 32'hFFFFFFFF, "R8 masked irq stays high");
    @(negedge clk);
    busWrEn = 1; busAddr = 12'h110; busWrData = 0; evtDone[0] = 1;
    @(negedge clk);
    busWrEn = 0; evtDone[0] = 0;
    rd(12'h110, 32'h01, 32'hFFFFFFFF, "R6 event beats clear");

    // R10
    wr(12'h1C0, 3);
    chk(32'(threadPrio[3 +: 3]), 3, "R10 prio output");
    rd(12'h1C0, 3, 32'hFFFFFFFF, "R10 prio readback");
    wr(12'h030, 32'h1234);
    rd(12'h030, 32'h1234, 32'hFFFFFFFF, "R10 slot readback");
    chk(slotCycles, 32'h1234, "R10 slot output");

    // R3 warm reset on thread1
    @(negedge clk);
    evtDone[1] = 1;
    @(negedge clk);
    evtDone[1] = 0;
    wr(12'h180, 1);
    chk(32'(coreReset[1]), 1, "R3 reset strobe high");
    chk(32'(coreRun[1]), 0, "R3 no run in reset");
    rd(12'h180, 1, 32'hFFFFFFFF, "R3 busy bit reads 1");
    repeat (8) @(negedge clk);
    rd(12'h180, 0, 32'hFFFFFFFF, "R3 busy bit self clears");
    rd(12'h184, 0, 32'hFFFFFFFF, "R3 enable cleared");
    rd(12'h190, 0, 32'hFFFFFFFF, "R3 irq status cleared");
    chk(32'(coreReset[1]), 0, "R3 reset strobe low");

    while (expQ.size() != 0) @(negedge clk);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule